// File: doc/BRIEF.md
# SPI Port with Multi-Master Fault Detection

This block is a byte-oriented SPI port that works either as the bus master or as a selected slave. In master mode it produces a serial clock that toggles only while a word is moving, at a rate set by a divider field, and drives MOSI. In slave mode it listens to an active-low select input, follows the clock from the bus, and drives MISO. Clock polarity and sampling phase come from a single control word written through a simple register port.

The port watches its select input while it is master. If another device pulls that input low, the port records a multi-master fault, abandons the word in flight, drops out of master mode, and releases SCK and MOSI. Software must clear the fault before it can be master again. For slave use, MISO can be switched to open-drain behaviour or switched off completely. Switching it off lets a master broadcast one byte to several slaves at once.

Words are 8 bits by default (parameter), most significant bit first. Received data is presented with a one-cycle completion pulse.

Top module: `spi_mm_port`

## Requirements
- R1: Control word layout: bit0 enable, bit1 master, bit2 clock polarity, bit3 clock phase, bit4 MISO open-drain, bit5 MISO disable, bit6 fault clear (write-only, always reads 0), bits [14:7] divider. Every other field reads back as written. All fields are 0 after reset.
- R2: In master mode SCK rests at the polarity level and makes exactly two transitions per bit, 16 for a word. Each half period lasts divider+1 system clocks, so the completion pulse is seen 16*(divider+1) clocks after the clock edge that accepted tx_start.
- R3: Bits travel MSB first in both directions. With phase 0, data is sampled on the edge leaving the idle level and changed on the edge returning to it. Phase 1 swaps the two edges. This holds for all four polarity/phase combinations, in both master and slave roles.
- R4: rx_done is high for exactly one cycle per completed word, and rx_data holds the received word in that cycle.
- R5: In slave mode the port acts only while ss_n_i is low. Clock transitions while ss_n_i is high do not advance the bit count and produce no completion.
- R6: In master mode the port drives SCK and MOSI and never MISO. In slave mode it drives only MISO.
- R7: In master mode, a low level on ss_n_i sets mm_err, clears the master bit, releases SCK and MOSI, and abandons any word in progress without a completion pulse.
- R8: mm_err stays set until a control write with bit6 = 1. While mm_err is set, a write without bit6 cannot set the master bit.
- R9: With bit4 = 1 the slave never drives MISO high: it enables the driver with value 0 for a 0 bit and releases the line for a 1 bit.
- R10: With bit5 = 1, miso_oe stays low while the slave still receives MOSI data.
- R11: tx_start is ignored while a word is in progress, in slave mode, and while mm_err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 15 | Control word to write |
| ctl_rdata | output | 15 | Current control word |
| mm_err | output | 1 | Sticky multi-master fault flag |
| tx_data | input | 8 | Word to transmit |
| tx_start | input | 1 | Start a master transfer |
| busy | output | 1 | Master transfer in progress |
| rx_data | output | 8 | Last received word |
| rx_done | output | 1 | One-cycle word completion pulse |
| sck_i | input | 1 | Serial clock from the bus (slave) |
| sck_o | output | 1 | Serial clock driven (master) |
| sck_oe | output | 1 | SCK driver enable |
| ss_n_i | input | 1 | Active-low select / fault sense |
| mosi_i | input | 1 | MOSI from the bus (slave) |
| mosi_o | output | 1 | MOSI driven (master) |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_i | input | 1 | MISO from the bus (master) |
| miso_o | output | 1 | MISO driven (slave) |
| miso_oe | output | 1 | MISO driver enable |

## Verification
The master role is swept over all four polarity/phase settings, two divider values and several bit patterns, each exchanged with a reference slave model. A failure here separates a wrong edge choice from a wrong bit order or a wrong frame length, because each of these shows up in a different check. The slave role is driven by a bench master in every mode and in the open-drain and disabled-MISO variants. A burst of clock pulses with the select high confirms that the bit counter holds. Fault tests raise the select during idle and during a word, try to regain master without clearing, and then clear; these steps separate a missing abort from a missing latch and from a missing clear.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
   localparam int FLAG_W   = 7;
   localparam int CTL_EN   = 0;
   localparam int CTL_MSTR = 1;
   localparam int CTL_CPOL = 2;
   localparam int CTL_CPHA = 3;
   localparam int CTL_ODM  = 4;
   localparam int CTL_MOFF = 5;
   localparam int CTL_CLR  = 6;

   typedef struct packed {
      logic moff;
      logic odm;
      logic cpha;
      logic cpol;
      logic mstr;
      logic en;
   } spi_mode_t;
endpackage

// File: rtl/spi_mm_sync.sv
module spi_mm_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mm_ctl.sv
module spi_mm_ctl
   import spi_mm_pkg::*;
#(
   parameter int DIV_W = 8,
   localparam int CTL_W = FLAG_W + DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             ss_low,
   output spi_mode_t        mode,
   output logic [DIV_W-1:0] div,
   output logic             err,
   output logic [CTL_W-1:0] rdata
);
   spi_mode_t        mode_q;
   logic [DIV_W-1:0] div_q;
   logic             err_q;
   logic             err_set;

   assign err_set = mode_q.en & mode_q.mstr & ss_low & ~err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         div_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         if (wr) begin
            mode_q.en   <= wdata[CTL_EN];
            mode_q.cpol <= wdata[CTL_CPOL];
            mode_q.cpha <= wdata[CTL_CPHA];
            mode_q.odm  <= wdata[CTL_ODM];
            mode_q.moff <= wdata[CTL_MOFF];
            mode_q.mstr <= wdata[CTL_MSTR] & (~err_q | wdata[CTL_CLR]);
            div_q       <= wdata[CTL_W-1:FLAG_W];
            if (wdata[CTL_CLR]) err_q <= 1'b0;
         end
         if (err_set) begin
            err_q       <= 1'b1;
            mode_q.mstr <= 1'b0;
         end
      end
   end

   assign mode  = mode_q;
   assign div   = div_q;
   assign err   = err_q;
   assign rdata = {div_q, 1'b0, mode_q.moff, mode_q.odm, mode_q.cpha,
                   mode_q.cpol, mode_q.mstr, mode_q.en};
endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master #(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 8,
   localparam int EDGES = 2 * WORD_W,
   localparam int EC_W  = $clog2(EDGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [DIV_W-1:0]  div,
   input  logic              start,
   input  logic [WORD_W-1:0] tx,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              dout,
   output logic              done,
   output logic [WORD_W-1:0] rx
);
   logic              tgl;
   logic [DIV_W-1:0]  hcnt;
   logic [EC_W-1:0]   ecnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] rxsh;
   logic [WORD_W-1:0] rx_next;
   logic              samp;
   logic              last;

   // even edge index = leading edge; phase 0 samples on leading edges
   assign samp    = ~ecnt[0] ^ cpha;
   assign last    = (ecnt == EC_W'(EDGES - 1));
   assign rx_next = {rxsh[WORD_W-2:0], miso};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         tgl   <= 1'b0;
         hcnt  <= '0;
         ecnt  <= '0;
         shreg <= '0;
         rxsh  <= '0;
         dout  <= 1'b0;
         done  <= 1'b0;
         rx    <= '0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            busy <= 1'b0;
            tgl  <= 1'b0;
            hcnt <= '0;
            ecnt <= '0;
         end else if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               hcnt  <= '0;
               ecnt  <= '0;
               shreg <= cpha ? tx : (tx << 1);
               dout  <= tx[WORD_W-1];
            end
         end else if (hcnt == div) begin
            hcnt <= '0;
            tgl  <= ~tgl;
            ecnt <= ecnt + 1'b1;
            if (samp) begin
               rxsh <= rx_next;
            end else begin
               dout  <= shreg[WORD_W-1];
               shreg <= shreg << 1;
            end
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
               rx   <= samp ? rx_next : rxsh;
            end
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   assign sck = cpol ^ tgl;
endmodule

// File: rtl/spi_mm_slave.sv
module spi_mm_slave #(
   parameter int WORD_W = 8,
   localparam int BC_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              sck_s,
   input  logic              ss_n_s,
   input  logic              mosi_s,
   input  logic [WORD_W-1:0] tx,
   output logic              sel,
   output logic              dout,
   output logic              done,
   output logic [WORD_W-1:0] rx
);
   logic              sck_d;
   logic              ss_d;
   logic [BC_W-1:0]   bcnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-2:0] rxsh;
   logic [WORD_W-1:0] rx_next;
   logic              edge_seen;
   logic              lead;
   logic              samp;
   logic              shft;

   assign sel       = act & ~ss_n_s;
   assign edge_seen = sck_s ^ sck_d;
   assign lead      = (sck_d == cpol);
   assign samp      = edge_seen & (lead ^ cpha);
   assign shft      = edge_seen & ~(lead ^ cpha);
   assign rx_next   = {rxsh, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         ss_d  <= 1'b1;
         bcnt  <= '0;
         shreg <= '0;
         rxsh  <= '0;
         dout  <= 1'b0;
         done  <= 1'b0;
         rx    <= '0;
      end else begin
         sck_d <= sck_s;
         ss_d  <= ss_n_s;
         done  <= 1'b0;
         if (!sel) begin
            bcnt <= '0;
         end else if (ss_d) begin
            bcnt  <= '0;
            shreg <= cpha ? tx : (tx << 1);
            dout  <= tx[WORD_W-1];
         end else if (samp) begin
            rxsh <= rx_next[WORD_W-2:0];
            if (bcnt == BC_W'(WORD_W - 1)) begin
               bcnt  <= '0;
               done  <= 1'b1;
               rx    <= rx_next;
               shreg <= tx;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end else if (shft) begin
            dout  <= shreg[WORD_W-1];
            shreg <= shreg << 1;
         end
      end
   end
endmodule

// File: rtl/spi_mm_port.sv
module spi_mm_port
   import spi_mm_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CTL_W = FLAG_W + DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic              mm_err,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_start,
   output logic              busy,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_done,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe
);
   if (WORD_W < 2) begin : g_bad_word
      $error("spi_mm_port: WORD_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_mm_port: DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_mm_port: SYNC_STAGES must be at least 2");
   end

   spi_mode_t         mode;
   logic [DIV_W-1:0]  div;
   logic              err;
   logic [2:0]        pins_s;
   logic              sck_s, ss_n_s, mosi_s;
   logic              run;
   logic              m_sck, m_out, m_done;
   logic [WORD_W-1:0] m_rx;
   logic              s_sel, s_out, s_done;
   logic [WORD_W-1:0] s_rx;

   spi_mm_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sck_i, ss_n_i, mosi_i}), .q(pins_s)
   );
   assign {sck_s, ss_n_s, mosi_s} = pins_s;

   spi_mm_ctl #(.DIV_W(DIV_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .ss_low(~ss_n_s), .mode(mode), .div(div), .err(err), .rdata(ctl_rdata)
   );

   assign run = mode.en & mode.mstr & ~err;

   spi_mm_master #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_mst (
      .clk(clk), .rst_n(rst_n), .run(run), .cpol(mode.cpol), .cpha(mode.cpha),
      .div(div), .start(tx_start), .tx(tx_data), .miso(miso_i),
      .busy(busy), .sck(m_sck), .dout(m_out), .done(m_done), .rx(m_rx)
   );

   spi_mm_slave #(.WORD_W(WORD_W)) u_slv (
      .clk(clk), .rst_n(rst_n), .act(mode.en & ~mode.mstr),
      .cpol(mode.cpol), .cpha(mode.cpha), .sck_s(sck_s), .ss_n_s(ss_n_s),
      .mosi_s(mosi_s), .tx(tx_data), .sel(s_sel), .dout(s_out),
      .done(s_done), .rx(s_rx)
   );

   assign mm_err  = err;
   assign sck_o   = m_sck;
   assign sck_oe  = run;
   assign mosi_o  = m_out;
   assign mosi_oe = run;
   assign miso_o  = s_out & ~mode.odm;
   assign miso_oe = s_sel & ~mode.moff & (~mode.odm | ~s_out);
   assign rx_done = m_done | s_done;
   assign rx_data = mode.mstr ? m_rx : s_rx;
endmodule

// File: rtl/spi_mm_port_chk.sv
module spi_mm_port_chk (
   input logic clk,
   input logic rst_n,
   input logic clr_wr,
   input logic cfg_mstr,
   input logic cfg_cpol,
   input logic cfg_odm,
   input logic cfg_moff,
   input logic mm_err,
   input logic busy,
   input logic rx_done,
   input logic sck_o,
   input logic sck_oe,
   input logic mosi_oe,
   input logic miso_o,
   input logic miso_oe
);
   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && !busy) |-> (sck_o == cfg_cpol));

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   assert_master_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mstr |-> !miso_oe);

   assert_slave_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mstr |-> (!sck_oe && !mosi_oe));

   assert_fault_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mm_err |-> (!sck_oe && !mosi_oe && !cfg_mstr));

   assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_err && !clr_wr) |=> mm_err);

   assert_open_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && cfg_odm) |-> !miso_o);

   assert_miso_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_moff |-> !miso_oe);
endmodule

bind spi_mm_port spi_mm_port_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .clr_wr(ctl_wr & ctl_wdata[spi_mm_pkg::CTL_CLR]),
   .cfg_mstr(ctl_rdata[spi_mm_pkg::CTL_MSTR]),
   .cfg_cpol(ctl_rdata[spi_mm_pkg::CTL_CPOL]),
   .cfg_odm(ctl_rdata[spi_mm_pkg::CTL_ODM]),
   .cfg_moff(ctl_rdata[spi_mm_pkg::CTL_MOFF]),
   .mm_err(mm_err), .busy(busy), .rx_done(rx_done),
   .sck_o(sck_o), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
   .miso_o(miso_o), .miso_oe(miso_oe)
);

// File: tb/spi_mm_port_tb.sv
`timescale 1ns/1ps
module spi_mm_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [14:0] ctl_wdata = '0;
   logic [14:0] ctl_rdata;
   logic        mm_err;
   logic [7:0]  tx_data = '0;
   logic        tx_start = 1'b0;
   logic        busy;
   logic [7:0]  rx_data;
   logic        rx_done;
   logic        sck_i = 1'b0;
   logic        sck_o, sck_oe;
   logic        ss_n_i = 1'b1;
   logic        mosi_i = 1'b0;
   logic        mosi_o, mosi_oe;
   logic        miso_i;
   logic        miso_o, miso_oe;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   spi_mm_port u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .mm_err(mm_err), .tx_data(tx_data),
      .tx_start(tx_start), .busy(busy), .rx_data(rx_data), .rx_done(rx_done),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_i(ss_n_i),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
      .miso_o(miso_o), .miso_oe(miso_oe)
   );

   // reference slave answering the DUT in master mode
   logic       mdl_cpol = 1'b0, mdl_cpha = 1'b0;
   logic [7:0] mdl_pre = '0, mdl_tx = '0, mdl_rx = '0;
   logic       mdl_out = 1'b0, mdl_sck_d = 1'b0;
   int         edge_cnt = 0;
   int         done_cnt = 0;

   assign miso_i = mdl_out;

   always @(posedge clk) begin
      mdl_sck_d <= sck_o;
      if (sck_oe && (sck_o != mdl_sck_d)) begin
         edge_cnt <= edge_cnt + 1;
         if ((mdl_sck_d == mdl_cpol) ^ mdl_cpha)
            mdl_rx <= {mdl_rx[6:0], mosi_o};
         else begin
            mdl_out <= mdl_tx[7];
            mdl_tx  <= mdl_tx << 1;
         end
      end else if (!busy) begin
         mdl_tx  <= mdl_cpha ? mdl_pre : (mdl_pre << 1);
         mdl_out <= mdl_pre[7];
      end
      if (rx_done) done_cnt <= done_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [6:0] flags, input logic [7:0] div);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = {div, flags};
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic pulse_start(input logic [7:0] d);
      @(negedge clk);
      tx_data = d;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
   endtask

   task automatic mst_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                           input logic cpol, input logic cpha, input logic [7:0] div);
      int e0, d0, n;
      mdl_cpol = cpol;
      mdl_cpha = cpha;
      mdl_pre = stx;
      wr_ctl({3'b000, cpha, cpol, 2'b11}, div);
      wait_n(4);
      e0 = edge_cnt;
      d0 = done_cnt;
      @(negedge clk);
      tx_data = mtx;
      tx_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_start = 1'b0;
      n = 0;
      while (!rx_done && n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk("R2 frame length", n, 16 * (div + 1));
      chk("R4 rx_data at done (R3 master rx)", rx_data, stx);
      chk("R6 master drivers", {sck_oe, mosi_oe, miso_oe}, 3'b110);
      wait_n(3);
      chk("R3 slave model got MOSI", mdl_rx, mtx);
      chk("R2 edge count", edge_cnt - e0, 16);
      chk("R2 idle level", sck_o, cpol);
      chk("R4 single done", done_cnt - d0, 1);
   endtask

   task automatic slv_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                           input logic cpol, input logic cpha,
                           input logic od, input logic moff, input string tag);
      int d0;
      logic [7:0] got;
      logic oe_seen;
      wr_ctl({1'b0, moff, od, cpha, cpol, 2'b01}, 8'd0);
      sck_i = cpol;
      ss_n_i = 1'b1;
      tx_data = stx;
      wait_n(6);
      chk({tag, " R6 slave drivers"}, {sck_oe, mosi_oe}, 2'b00);
      d0 = done_cnt;
      got = '0;
      oe_seen = 1'b0;
      ss_n_i = 1'b0;
      wait_n(6);
      for (int i = 0; i < 8; i++) begin
         if (!cpha) begin
            mosi_i = mtx[7-i];
            wait_n(8);
            sck_i = ~cpol;
            wait_n(4);
            got = {got[6:0], od ? ~miso_oe : miso_o};
            oe_seen = oe_seen | miso_oe;
            wait_n(4);
            sck_i = cpol;
         end else begin
            sck_i = ~cpol;
            mosi_i = mtx[7-i];
            wait_n(8);
            got = {got[6:0], od ? ~miso_oe : miso_o};
            oe_seen = oe_seen | miso_oe;
            sck_i = cpol;
            wait_n(8);
         end
      end
      wait_n(8);
      chk({tag, " R5 R4 slave done count"}, done_cnt - d0, 1);
      chk({tag, " R3 slave rx_data"}, rx_data, mtx);
      if (moff)
         chk({tag, " R10 miso never enabled"}, oe_seen, 1'b0);
      else
         chk({tag, od ? " R9 open-drain MISO bits" : " R3 slave MISO bits"}, got, stx);
      ss_n_i = 1'b1;
      wait_n(6);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] m, s;
      int d0;
      wait_n(3);
      chk("R1 reset ctl", ctl_rdata, 15'h0);
      chk("R6 reset drivers", {sck_oe, mosi_oe, miso_oe, mm_err, rx_done}, 5'b0);
      rst_n = 1'b1;
      wait_n(2);

      // R1 register readback; bit6 is write-only
      wr_ctl(7'h7D, 8'hA6);
      wait_n(1);
      chk("R1 readback", ctl_rdata, {8'hA6, 7'h3D});
      wr_ctl(7'h00, 8'h5A);
      wait_n(1);
      chk("R1 readback div", ctl_rdata, {8'h5A, 7'h00});

      // R2 R3 R4 master sweep
      for (int mode = 0; mode < 4; mode++) begin
         for (int k = 0; k < 4; k++) begin
            m = 8'hA5 ^ 8'(k * 37 + mode * 11);
            s = {~m[3:0], m[7:4]} ^ 8'(k);
            mst_xfer(m, s, mode[1], mode[0], 8'(1 + 2 * (k % 2)));
         end
      end
      mst_xfer(8'h00, 8'hFF, 1'b0, 1'b0, 8'd1);
      mst_xfer(8'h80, 8'h01, 1'b1, 1'b1, 8'd2);

      // R11 start while busy is ignored
      mdl_cpol = 1'b0; mdl_cpha = 1'b0; mdl_pre = 8'h3C;
      wr_ctl(7'h03, 8'd1);
      wait_n(3);
      d0 = done_cnt;
      pulse_start(8'h96);
      wait_n(5);
      pulse_start(8'h0F);
      wait_n(60);
      chk("R11 start while busy ignored", done_cnt - d0, 1);
      chk("R11 first word kept", mdl_rx, 8'h96);

      // R3 slave sweep
      for (int mode = 0; mode < 4; mode++)
         slv_xfer(8'h3A + 8'(mode * 29), 8'hC5 ^ 8'(mode * 51), mode[1], mode[0], 1'b0, 1'b0, "plain");
      slv_xfer(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "edge");
      // R9 open drain
      slv_xfer(8'h12, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, "od0");
      slv_xfer(8'h6E, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, "od3");
      // R10 MISO disabled, data still received
      slv_xfer(8'hB7, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, "moff");

      // R5 clock ignored while deselected
      wr_ctl(7'h01, 8'd0);
      sck_i = 1'b0; ss_n_i = 1'b1;
      wait_n(4);
      d0 = done_cnt;
      for (int i = 0; i < 8; i++) begin
         mosi_i = i[0];
         sck_i = 1'b1; wait_n(6);
         sck_i = 1'b0; wait_n(6);
      end
      wait_n(6);
      chk("R5 no done while deselected", done_cnt - d0, 0);
      slv_xfer(8'h59, 8'h2D, 1'b0, 1'b0, 1'b0, 1'b0, "after_ignore R5");

      // R11 start ignored in slave mode
      pulse_start(8'h11);
      wait_n(3);
      chk("R11 slave start ignored", {busy, sck_oe}, 2'b00);

      // R7 fault in idle master
      wr_ctl(7'h03, 8'd1);
      wait_n(2);
      ss_n_i = 1'b0;
      wait_n(6);
      chk("R7 fault set", mm_err, 1'b1);
      chk("R7 master bit cleared", ctl_rdata[1], 1'b0);
      chk("R7 pins released", {sck_oe, mosi_oe}, 2'b00);
      ss_n_i = 1'b1;
      wait_n(4);
      d0 = done_cnt;
      pulse_start(8'h44);
      wait_n(4);
      chk("R11 start ignored under fault", {busy, 8'(done_cnt - d0)}, 9'h0);
      // R8 no re-entry without clear
      wr_ctl(7'h03, 8'd1);
      wait_n(2);
      chk("R8 fault held", mm_err, 1'b1);
      chk("R8 master refused", ctl_rdata[1], 1'b0);
      wr_ctl(7'h43, 8'd1);
      wait_n(2);
      chk("R8 fault cleared", mm_err, 1'b0);
      chk("R8 master regained", {ctl_rdata[1], sck_oe, ctl_rdata[6]}, 3'b110);

      // R7 fault during a word aborts it
      mdl_pre = 8'h77;
      wr_ctl(7'h03, 8'd3);
      wait_n(2);
      d0 = done_cnt;
      pulse_start(8'hE1);
      wait_n(20);
      chk("R7 word running", busy, 1'b1);
      ss_n_i = 1'b0;
      wait_n(80);
      chk("R7 abort no done", done_cnt - d0, 0);
      chk("R7 abort state", {mm_err, busy, sck_oe, mosi_oe}, 4'b1000);
      ss_n_i = 1'b1;
      wr_ctl(7'h43, 8'd1);
      wait_n(2);
      mst_xfer(8'h5C, 8'hC3, 1'b1, 1'b0, 8'd1);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule